// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the three panel control signals (horizontal sync, vertical sync and data enable) on the display clock. A horizontal pixel counter and a vertical line counter define the raster. Both counters are zero at the leading edge of their own sync pulse. Every edge position comes from a configuration input: the sync widths, the start and size of the active window, and the totals that close a line and a frame.

Two operating modes are available. In free-running operation the programmed totals alone set the frame and the frame-start input has no effect. In locked operation an input frame-start pulse restarts the raster at pixel 0, line 0 on the next clock. If no pulse arrives, the frame still wraps at the vertical total. A double-width option advances the horizontal counter by two pixels per clock for panels that take two pixels per clock. In that mode every horizontal setting must be even.

Configuration is captured into shadow registers only at the start of a frame, so one frame never mixes old and new settings. The block has no data stream. All of its pins are plain control and status pins with no handshake.

Top module: `disp_timing_gen`

## Requirements
- R1: During synchronous reset (rst_n low) and on the first clock after release, the raster is at pixel 0, line 0. The configuration inputs present during reset are captured as the active settings.
- R2: The horizontal counter advances by one pixel per clock and returns to 0 when the next count would reach or exceed the active horizontal total. hsync is 1 exactly while the pixel count is below the horizontal sync width.
- R3: The line counter advances by one only on the clock where the pixel counter wraps. It returns to 0 when the next line would reach or exceed the vertical total. vsync is 1 exactly while the line count is below the vertical sync width.
- R4: de is 1 only when both of the following hold: the pixel count lies in [h_act_start, h_act_start + h_act_width), and the line count lies in [v_act_start, v_act_start + v_act_height).
- R5: With free-running operation active (cfg_locked = 0), frame_start_in has no effect on hsync, vsync or de.
- R6: With locked operation active (cfg_locked = 1), a clock with frame_start_in = 1 puts the raster at pixel 0, line 0 on the next clock. This restart takes priority over the normal counting.
- R7: With locked operation active and no frame_start_in pulse, the raster wraps at the programmed totals exactly as in free-running operation.
- R8: With double width active (cfg_dual = 1), the pixel counter advances by two per clock and stays even. The wrap rule of R2 uses the step of two.
- R9: All configuration inputs, including cfg_locked and cfg_dual, are captured only at a frame start: on reset, on a frame wrap, or on a locked restart. Changes made in mid-frame do not affect the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_h_total | input | HW | Pixels per line |
| cfg_h_sync | input | HW | Horizontal sync width in pixels |
| cfg_h_act_start | input | HW | First active pixel |
| cfg_h_act_width | input | HW | Active pixels per line |
| cfg_v_total | input | VW | Lines per frame |
| cfg_v_sync | input | VW | Vertical sync width in lines |
| cfg_v_act_start | input | VW | First active line |
| cfg_v_act_height | input | VW | Active lines per frame |
| cfg_locked | input | 1 | 1 = frame-sync to frame_start_in, 0 = free run |
| cfg_dual | input | 1 | 1 = two pixels per clock |
| frame_start_in | input | 1 | Input frame-start pulse, used only when locked |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, active high |

## Verification
The bench aims at the points where a counter wraps and at the boundaries of each window. An off-by-one in the total or window compare shows up at once as a line one pixel too long or a data-enable one clock late. The bench also sends frame-start pulses while the block is free-running, where a design that honoured them would cut frames short. Locked pulses land mid-line and mid-frame, which shows whether the restart beats the normal wrap. Configuration is changed in the middle of a frame, so a design without shadowing tears that frame at once. In double-width mode with even settings, a counter that stepped by one would drift off the expected wrap points within the first line.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DEF_HW = 12;
  localparam int DEF_VW = 11;

  typedef enum logic {
    RUN_FREE   = 1'b0,
    RUN_LOCKED = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/dtg_cfg_latch.sv
module dtg_cfg_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Reset captures the live inputs so the first frame already uses them.
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= d;
    else if (load) q <= d;
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/dtg_raster_cnt.sv
module dtg_raster_cnt #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  input  logic          dual,
  input  logic          restart,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          frame_wrap
);
  localparam int HS = HW + 1;
  localparam int VS = VW + 1;

  logic [HS-1:0] h_next;
  logic [VS-1:0] v_next;
  logic          h_wrap;
  logic          v_wrap;

  always_comb begin
    h_next = {1'b0, h_cnt} + (dual ? HS'(2) : HS'(1));
    v_next = {1'b0, v_cnt} + VS'(1);
    h_wrap = h_next >= {1'b0, h_total};
    v_wrap = v_next >= {1'b0, v_total};
  end

  assign frame_wrap = h_wrap && v_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_wrap) begin
      h_cnt <= '0;
      v_cnt <= v_wrap ? '0 : v_next[VW-1:0];
    end else begin
      h_cnt <= h_next[HW-1:0];
    end
  end

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (h_cnt == '0 && v_cnt == '0));
  assert_h_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_total != '0) |-> (h_cnt < h_total));
  assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !h_wrap) |=> $stable(v_cnt));
  assert_dual_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !h_cnt[0]);
endmodule

// File: rtl/dtg_window.sv
module dtg_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] sync_w,
  input  logic [W-1:0] act_start,
  input  logic [W-1:0] act_size,
  output logic         in_sync,
  output logic         in_act
);
  logic [W:0] act_end;

  always_comb begin
    act_end = {1'b0, act_start} + {1'b0, act_size};
    in_sync = pos < sync_w;
    in_act  = (pos >= act_start) && ({1'b0, pos} < act_end);
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int HW = dtg_pkg::DEF_HW,
  parameter int VW = dtg_pkg::DEF_VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_sync,
  input  logic [HW-1:0] cfg_h_act_start,
  input  logic [HW-1:0] cfg_h_act_width,
  input  logic [VW-1:0] cfg_v_total,
  input  logic [VW-1:0] cfg_v_sync,
  input  logic [VW-1:0] cfg_v_act_start,
  input  logic [VW-1:0] cfg_v_act_height,
  input  logic          cfg_locked,
  input  logic          cfg_dual,
  input  logic          frame_start_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de
);
  import dtg_pkg::*;

  localparam int CW = 4 * HW + 4 * VW + 2;

  logic [CW-1:0] cfg_live;
  logic [CW-1:0] cfg_act;
  logic [HW-1:0] a_ht, a_hs, a_hst, a_hw;
  logic [VW-1:0] a_vt, a_vs, a_vst, a_vh;
  sync_mode_e    a_mode;
  logic          a_dual;
  logic          restart;
  logic          frame_wrap;
  logic          frame_load;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_sync_i, h_act_i, v_sync_i, v_act_i;

  assign cfg_live = {cfg_h_total, cfg_h_sync, cfg_h_act_start, cfg_h_act_width,
                     cfg_v_total, cfg_v_sync, cfg_v_act_start, cfg_v_act_height,
                     cfg_locked, cfg_dual};

  logic a_lock_bit;
  assign {a_ht, a_hs, a_hst, a_hw, a_vt, a_vs, a_vst, a_vh, a_lock_bit, a_dual} = cfg_act;
  assign a_mode = sync_mode_e'(a_lock_bit);

  assign restart    = (a_mode == RUN_LOCKED) && frame_start_in;
  assign frame_load = restart || frame_wrap;

  dtg_cfg_latch #(.W(CW)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frame_load),
    .d    (cfg_live),
    .q    (cfg_act)
  );

  dtg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_total   (a_ht),
    .v_total   (a_vt),
    .dual      (a_dual),
    .restart   (restart),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .frame_wrap(frame_wrap)
  );

  dtg_window #(.W(HW)) u_hwin (
    .pos      (h_cnt),
    .sync_w   (a_hs),
    .act_start(a_hst),
    .act_size (a_hw),
    .in_sync  (h_sync_i),
    .in_act   (h_act_i)
  );

  dtg_window #(.W(VW)) u_vwin (
    .pos      (v_cnt),
    .sync_w   (a_vs),
    .act_start(a_vst),
    .act_size (a_vh),
    .in_sync  (v_sync_i),
    .in_act   (v_act_i)
  );

  assign hsync = h_sync_i;
  assign vsync = v_sync_i;
  assign de    = h_act_i && v_act_i;

  assert_free_ignores_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode == RUN_FREE && !frame_wrap) |=> (h_cnt != '0 || $past(h_cnt) != '0 || v_cnt == $past(v_cnt)));
  assert_de_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (v_cnt >= a_vst));
endmodule

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] ht, hs, hst, hw;
  logic [VW-1:0] vt, vs, vst, vh;
  logic locked, dual, fpulse;
  logic hsync, vsync, de;

  always #10 clk = ~clk;

  disp_timing_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(ht), .cfg_h_sync(hs), .cfg_h_act_start(hst), .cfg_h_act_width(hw),
    .cfg_v_total(vt), .cfg_v_sync(vs), .cfg_v_act_start(vst), .cfg_v_act_height(vh),
    .cfg_locked(locked), .cfg_dual(dual), .frame_start_in(fpulse),
    .hsync(hsync), .vsync(vsync), .de(de)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit started = 0;
  string phase = "R1";

  // behavioural reference state
  int m_h, m_v;
  int s_ht, s_hs, s_hst, s_hw, s_vt, s_vs, s_vst, s_vh;
  bit s_lock, s_dual;

  task automatic take_cfg();
    s_ht = ht; s_hs = hs; s_hst = hst; s_hw = hw;
    s_vt = vt; s_vs = vs; s_vst = vst; s_vh = vh;
    s_lock = locked; s_dual = dual;
  endtask

  always @(posedge clk) begin
    int step;
    started = 1;
    if (!rst_n) begin
      m_h = 0; m_v = 0; take_cfg();
    end else if (s_lock && fpulse) begin
      m_h = 0; m_v = 0; take_cfg();
    end else begin
      step = s_dual ? 2 : 1;
      if (m_h + step >= s_ht) begin
        m_h = 0;
        if (m_v + 1 >= s_vt) begin
          m_v = 0; take_cfg();
        end else m_v = m_v + 1;
      end else m_h = m_h + step;
    end
  end

  task automatic check(input string tag, input logic act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (%s) at cycle %0d h=%0d v=%0d: actual %b expected %b",
               tag, phase, cyc, m_h, m_v, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R2 hsync", hsync, m_h < s_hs);
      check("R3 vsync", vsync, m_v < s_vs);
      check("R4 de", de, (m_h >= s_hst) && (m_h < s_hst + s_hw) &&
                          (m_v >= s_vst) && (m_v < s_vst + s_vh));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic run(input int n, input int pulse_every);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      fpulse = (pulse_every > 0) && (i % pulse_every == pulse_every - 1);
    end
    @(posedge clk); #2; fpulse = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: first cycle after release is pixel 0 line 0 with reset-time settings
    compared++;
    if (hsync !== (hs != 0) || vsync !== (vs != 0)) begin
      mismatched++;
      $display("FAIL R1 reset state: actual hs=%b vs=%b expected hs=%b vs=%b",
               hsync, vsync, hs != 0, vs != 0);
    end
  endtask

  initial begin
    ht = 20; hs = 3; hst = 5; hw = 12;
    vt = 8;  vs = 2; vst = 3; vh = 4;
    locked = 0; dual = 0; fpulse = 0;
    phase = "R1";
    do_reset();
    phase = "R2/R3/R4";
    run(330, 0);
    phase = "R5";                 // pulses while free-running
    run(300, 37);
    phase = "R6";                 // locked restart, mid-line pulses
    locked = 1;
    run(700, 93);
    phase = "R7";                 // locked, no pulse
    run(400, 0);
    phase = "R9";                 // mid-frame change, lock off
    run(45, 0);
    ht = 18; hs = 2; hst = 4; hw = 10; vst = 2; vh = 5; locked = 0;
    run(500, 0);
    phase = "R8";                 // double width, even settings
    ht = 24; hs = 4; hst = 6; hw = 14; dual = 1;
    run(700, 0);
    phase = "R1";
    ht = 16; hs = 0; hst = 0; hw = 8; vt = 6; vs = 1; vst = 0; vh = 3; dual = 0;
    do_reset();
    run(200, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule